// File: doc/BRIEF.md
# Hot-Swap Board Status and Extraction Logic

This block is the small piece of control logic on a plug-in board that sits between the board's power controller and the backplane. It combines three power status indications into a single active-low healthy output. It derives the board-local bus reset from the backplane reset, and forces that reset the instant health is lost. It turns the active-low slot-select line from the backplane into the power-on request for the power controller.

The block also handles the ejector handle. The raw switch is debounced. When the handle is opened on a healthy board, the block pulls the open-drain enumeration line low to tell software that an extraction is pending. Software then quiesces the board's I/O and pulses a done strobe, and the block lights a safe-to-remove LED. If the handle is closed again before software reports completion, the extraction request is withdrawn.

There are no streaming data paths. Every pin is a plain level or a single-cycle strobe, so nothing here uses valid/ready or back-pressure.

Top module: `hs_status_glue`

## Requirements
- R1: `healthy_n` is 0 exactly when `fault_flag` is 0, the power-on request is 1 and the filtered output-good sense is 1. Otherwise it is 1.
- R2: `pwr_on` is the inverse of `slot_sel_n` at all times, and it is the power-on request used by R1.
- R3: A change on `out_good` counts toward R1 only after the new value has been sampled on GOOD_HOLD (8) consecutive rising clock edges. A shorter excursion has no effect on `healthy_n`.
- R4: While `healthy_n` is 1, `local_rst_n` is 0 in the same cycle, without waiting for a clock edge and whatever `bp_rst_n` is doing.
- R5: While `healthy_n` is 0, `local_rst_n` equals `bp_rst_n`.
- R6: A change on `eject_open` (1 = handle open) is accepted only after the new value has been sampled on EJECT_HOLD (1024) consecutive rising edges.
- R7: One clock after an accepted opening of the handle while healthy, `enum_drive_low` becomes 1. The request then stays set until an `enum_clr` pulse or a cancel (R10).
- R8: `enum_drive_low` is 0 whenever `healthy_n` is 1. The pending request is kept and reappears when health returns.
- R9: A `quiesce_done` pulse during a pending extraction turns `remove_led` on one clock later. A `quiesce_done` pulse with no extraction pending is ignored.
- R10: If the accepted handle state returns to closed while an extraction is pending and the LED is still off, the request is cancelled on the next clock: `enum_drive_low` goes to 0 and the LED stays off. This cancel wins over a `quiesce_done` pulse in the same cycle.
- R11: With `remove_led` on, an accepted closing of the handle turns the LED off on the next clock.
- R12: While `rst_n` is 0 and right after it rises, `healthy_n`=1, `local_rst_n`=0, `enum_drive_low`=0 and `remove_led`=0. Both filters start from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_flag | input | 1 | Power controller fault, 1 = fault |
| slot_sel_n | input | 1 | Backplane slot select, active low |
| out_good | input | 1 | Raw output-good sense from the supply |
| bp_rst_n | input | 1 | Backplane bus reset, active low |
| eject_open | input | 1 | Raw ejector switch, 1 = handle open |
| quiesce_done | input | 1 | Software strobe: I/O quiesced |
| enum_clr | input | 1 | Software strobe: release enumeration line |
| pwr_on | output | 1 | Power-on request to the power controller |
| healthy_n | output | 1 | Board healthy, active low |
| local_rst_n | output | 1 | Board-local bus reset, active low |
| enum_drive_low | output | 1 | 1 = pull the open-drain enumeration line low |
| remove_led | output | 1 | Safe-to-remove indicator |

## Verification
Two functions can act in the same clock: the cancel caused by the debounced handle returning to closed, and the software quiesce-done strobe. The bench closes the handle and waits exactly the debounce period, so the strobe lands on the edge where the extraction logic first sees the closed state. It then requires both the LED and the enumeration drive to be off. A second collision removes slot select while a request is pending. This tests that the combinational health loss masks the enumeration line and forces the local reset within the same cycle, and that the request comes back once health returns.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_SAFE = 2'd2
  } xstate_t;
endpackage

// File: rtl/hs_debounce.sv
module hs_debounce #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (raw != filt) begin
      if (cnt == LAST) begin
        filt <= raw;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R3 and R6: the filtered value only ever moves to the raw value seen at the edge
  p_db_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> (filt == $past(raw)));
endmodule

// File: rtl/hs_health_gate.sv
module hs_health_gate (
  input  logic fault_flag,
  input  logic slot_sel_n,
  input  logic good_filt,
  input  logic bp_rst_n,
  output logic pwr_on,
  output logic healthy,
  output logic local_rst_n
);
  always_comb begin
    pwr_on      = ~slot_sel_n;
    healthy     = ~fault_flag & pwr_on & good_filt;
    local_rst_n = healthy & bp_rst_n;
  end
endmodule

// File: rtl/hs_extract_fsm.sv
module hs_extract_fsm
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic eject_db,
  input  logic healthy,
  input  logic quiesce_done,
  input  logic enum_clr,
  output logic enum_drive_low,
  output logic remove_led
);
  xstate_t st;
  logic    eject_q;
  logic    enum_flag;
  logic    rise;
  logic    cancel;

  assign rise   = eject_db & ~eject_q;
  assign cancel = (st == XS_WAIT) & ~eject_db;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= XS_IDLE;
      eject_q <= 1'b0;
    end else begin
      eject_q <= eject_db;
      case (st)
        XS_IDLE: if (rise && healthy) st <= XS_WAIT;
        XS_WAIT: begin
          if (!eject_db)         st <= XS_IDLE;
          else if (quiesce_done) st <= XS_SAFE;
        end
        XS_SAFE: if (!eject_db) st <= XS_IDLE;
        default: st <= XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                enum_flag <= 1'b0;
    else if (st == XS_IDLE && rise && healthy) enum_flag <= 1'b1;
    else if (enum_clr || cancel)               enum_flag <= 1'b0;
  end

  assign enum_drive_low = enum_flag & healthy;
  assign remove_led     = (st == XS_SAFE);

  // R9: LED only lights after a quiesce strobe
  p_led_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remove_led) |-> $past(quiesce_done));
  // R10: a cancel clears the request and returns to idle
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (st == XS_IDLE && !enum_flag));
  // R7: pending request holds until cleared or cancelled
  p_enum_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enum_flag && !enum_clr && !cancel) |=> enum_flag);
endmodule

// File: rtl/hs_status_glue.sv
module hs_status_glue #(
  parameter int GOOD_HOLD  = 8,
  parameter int EJECT_HOLD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_flag,
  input  logic slot_sel_n,
  input  logic out_good,
  input  logic bp_rst_n,
  input  logic eject_open,
  input  logic quiesce_done,
  input  logic enum_clr,
  output logic pwr_on,
  output logic healthy_n,
  output logic local_rst_n,
  output logic enum_drive_low,
  output logic remove_led
);
  logic good_filt;
  logic eject_db;
  logic healthy;

  hs_debounce #(.HOLD(GOOD_HOLD)) u_good_flt (
    .clk(clk), .rst_n(rst_n), .raw(out_good), .filt(good_filt)
  );

  hs_debounce #(.HOLD(EJECT_HOLD)) u_eject_flt (
    .clk(clk), .rst_n(rst_n), .raw(eject_open), .filt(eject_db)
  );

  hs_health_gate u_gate (
    .fault_flag(fault_flag), .slot_sel_n(slot_sel_n), .good_filt(good_filt),
    .bp_rst_n(bp_rst_n), .pwr_on(pwr_on), .healthy(healthy),
    .local_rst_n(local_rst_n)
  );

  hs_extract_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .eject_db(eject_db), .healthy(healthy),
    .quiesce_done(quiesce_done), .enum_clr(enum_clr),
    .enum_drive_low(enum_drive_low), .remove_led(remove_led)
  );

  assign healthy_n = ~healthy;

  // R8: enumeration drive masked while unhealthy
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    healthy_n |-> !enum_drive_low);
  // R4: local reset held whenever health is lost
  p_rst_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    healthy_n |-> !local_rst_n);
endmodule

// File: tb/sim_hs_status_glue.sv
`timescale 1ns/1ps
module sim_hs_status_glue;
  localparam int GH = 8;
  localparam int EH = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_flag = 1'b0, slot_sel_n = 1'b1, out_good = 1'b0, bp_rst_n = 1'b0;
  logic eject_open = 1'b0, quiesce_done = 1'b0, enum_clr = 1'b0;
  logic pwr_on, healthy_n, local_rst_n, enum_drive_low, remove_led;

  always #2.5 clk = ~clk;

  hs_status_glue #(.GOOD_HOLD(GH), .EJECT_HOLD(EH)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_flag(fault_flag), .slot_sel_n(slot_sel_n),
    .out_good(out_good), .bp_rst_n(bp_rst_n), .eject_open(eject_open),
    .quiesce_done(quiesce_done), .enum_clr(enum_clr), .pwr_on(pwr_on),
    .healthy_n(healthy_n), .local_rst_n(local_rst_n),
    .enum_drive_low(enum_drive_low), .remove_led(remove_led)
  );

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference model
  int  m_gcnt = 0, m_ecnt = 0, m_st = 0;
  bit  m_gf = 0, m_edb = 0, m_eq = 0, m_enf = 0;

  always @(posedge clk) begin
    bit h, rise;
    if (!rst_n) begin
      m_gcnt = 0; m_ecnt = 0; m_st = 0; m_gf = 0; m_edb = 0; m_eq = 0; m_enf = 0;
    end else begin
      h    = !fault_flag && !slot_sel_n && m_gf;
      rise = m_edb && !m_eq;
      case (m_st)
        0: if (rise && h) begin m_st = 1; m_enf = 1; end
           else if (enum_clr) m_enf = 0;
        1: if (!m_edb) begin m_st = 0; m_enf = 0; end
           else begin if (quiesce_done) m_st = 2; if (enum_clr) m_enf = 0; end
        default: begin if (!m_edb) m_st = 0; if (enum_clr) m_enf = 0; end
      endcase
      m_eq = m_edb;
      if (out_good != m_gf) begin
        if (m_gcnt == GH-1) begin m_gf = out_good; m_gcnt = 0; end else m_gcnt++;
      end else m_gcnt = 0;
      if (eject_open != m_edb) begin
        if (m_ecnt == EH-1) begin m_edb = eject_open; m_ecnt = 0; end else m_ecnt++;
      end else m_ecnt = 0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // compare against model every clock, away from the active edge
  always @(negedge clk) begin
    bit hm;
    if (rst_n && !done) begin
      hm = !fault_flag && !slot_sel_n && m_gf;
      chk("R1 healthy_n", healthy_n, !hm);
      chk("R2 pwr_on", pwr_on, !slot_sel_n);
      chk("R5 local_rst_n", local_rst_n, hm && bp_rst_n);
      chk("R7 enum_drive_low", enum_drive_low, m_enf && hm);
      chk("R9 remove_led", remove_led, m_st == 2);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    cyc(3);
    chk("R12 healthy_n in reset", healthy_n, 1'b1);
    chk("R12 local_rst_n in reset", local_rst_n, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R12 enum after reset", enum_drive_low, 1'b0);
    chk("R12 led after reset", remove_led, 1'b0);

    // power up
    slot_sel_n = 1'b0; out_good = 1'b1;
    #1 chk("R2 pwr_on follows select", pwr_on, 1'b1);
    cyc(GH-1);
    chk("R3 good not yet accepted", healthy_n, 1'b1);
    cyc(1);
    chk("R3 good accepted after hold", healthy_n, 1'b0);
    chk("R5 local reset follows backplane low", local_rst_n, 1'b0);
    bp_rst_n = 1'b1;
    #1 chk("R5 local reset follows backplane high", local_rst_n, 1'b1);

    // short glitch on good sense
    cyc(1); out_good = 1'b0; cyc(3); out_good = 1'b1; cyc(GH+2);
    chk("R3 glitch ignored", healthy_n, 1'b0);

    // fault drops health and local reset in the same cycle
    fault_flag = 1'b1;
    #1 chk("R1 fault drops healthy", healthy_n, 1'b1);
    chk("R4 local reset forced", local_rst_n, 1'b0);
    cyc(2); fault_flag = 1'b0; cyc(2);

    // quiesce with nothing pending is ignored
    quiesce_done = 1'b1; cyc(1); quiesce_done = 1'b0; cyc(1);
    chk("R9 idle quiesce ignored", remove_led, 1'b0);

    // open handle
    eject_open = 1'b1;
    cyc(EH);
    chk("R6 opening not yet seen", enum_drive_low, 1'b0);
    cyc(1);
    chk("R7 extraction announced", enum_drive_low, 1'b1);

    // health loss masks the request, which then returns
    slot_sel_n = 1'b1;
    #1 chk("R8 enum masked", enum_drive_low, 1'b0);
    chk("R4 local reset on deselect", local_rst_n, 1'b0);
    cyc(3); slot_sel_n = 1'b0; cyc(1);
    chk("R8 request returns", enum_drive_low, 1'b1);

    // quiesce, then clear enumeration
    quiesce_done = 1'b1; cyc(1); quiesce_done = 1'b0;
    chk("R9 led on after quiesce", remove_led, 1'b1);
    enum_clr = 1'b1; cyc(1); enum_clr = 1'b0;
    chk("R7 enum cleared", enum_drive_low, 1'b0);

    // close handle with LED on
    eject_open = 1'b0;
    cyc(EH);
    chk("R11 led still on during debounce", remove_led, 1'b1);
    cyc(1);
    chk("R11 led off after closing", remove_led, 1'b0);

    // open again, then close colliding with quiesce strobe
    cyc(2); eject_open = 1'b1; cyc(EH+1);
    chk("R7 second announce", enum_drive_low, 1'b1);
    cyc(5); eject_open = 1'b0; cyc(EH);
    quiesce_done = 1'b1; cyc(1); quiesce_done = 1'b0;
    chk("R10 cancel beats quiesce led", remove_led, 1'b0);
    chk("R10 cancel clears enum", enum_drive_low, 1'b0);
    cyc(4);
    chk("R10 led stays off", remove_led, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule